// File: doc/BRIEF.md
# Rotate-Through-Carry Right Unit

This block rotates an operand to the right through the carry flag, in the way a general-purpose processor's rotate-through-carry instruction does. The carry bit sits above the operand's most significant bit and forms a closed ring with it. Each single-step rotate moves the old carry into the operand's top bit, shifts every operand bit one place down, and moves the bit that leaves the bottom into the carry. The operand can be 8, 16, 32 or 64 bits wide, so the ring is 9, 17, 33 or 65 bits long.

The raw count (an immediate byte, or the low byte of a count register) is first masked to the width that the operand size allows. For the two narrow sizes it is then reduced modulo the ring length. The whole rotate is done by one ring rotate in a single clock, not by stepping through the count. The block also produces the new carry and the new overflow flag, and a write enable for the flags. The write enable stays low when the masked count is zero, because then no flag may change.

Decode, memory access and register writeback belong to the surrounding pipeline. One operation is accepted per cycle, and its registered result appears on the following clock edge.

Top module: `rcr_unit`

## Requirements
- R1: For every size, the result and the new carry equal the given number of single-step rotates of the ring {carry, operand}. In each step the old carry enters the operand's top bit and the old bit 0 becomes the carry. Example: 16-bit 0x1234 with carry 0 rotated by 4 gives 0x8123.
- R2: `op_size` selects the width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is 64 bits. Operand bits above the selected width are ignored, and the result drives them to zero.
- R3: The count is masked to `raw_count[5:0]` for size 3 and to `raw_count[4:0]` for the other sizes. So 33 acts as 1 on a 32-bit operand, and 64 acts as 0 on a 64-bit operand.
- R4: For size 0 the masked count is reduced modulo 9, and for size 1 modulo 17. A count of 9 on a byte, or 17 on a halfword, returns both the original operand and the original carry, with `flags_we` high.
- R5: When the masked count is zero, the result equals the operand within the selected width. `carry_out` equals `carry_in`, `ovf_out` equals `ovf_in`, and `flags_we` is 0.
- R6: When the masked count is nonzero, `flags_we` is 1.
- R7: When the masked count is 1, `ovf_out` is the XOR of the result's two highest bits within the selected width.
- R8: When the masked count is greater than 1, `ovf_out` equals `ovf_in`.
- R9: Outputs are registered, with a latency of one clock. `out_valid` is `in_valid` delayed by one cycle. Reset clears `out_valid`, `result`, `carry_out`, `ovf_out` and `flags_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented this cycle |
| op_size | input | 2 | Operand width select (0:8, 1:16, 2:32, 3:64) |
| operand | input | 64 | Value to rotate |
| raw_count | input | 8 | Unmasked rotate count |
| carry_in | input | 1 | Incoming carry flag |
| ovf_in | input | 1 | Incoming overflow flag |
| out_valid | output | 1 | Result registers hold a new operation |
| result | output | 64 | Rotated value, zero above the selected width |
| carry_out | output | 1 | New carry flag |
| ovf_out | output | 1 | New overflow flag |
| flags_we | output | 1 | Flags should be written |

## Verification
Two functions can act on the same operation: the zero-count rule and the modulo reduction. A byte count of 9, 18 or 27, or a halfword count of 17, reduces to a rotate by zero, so the value leaves the ring unchanged, as it does for a true zero count. The two cases differ only in `flags_we`, and for a masked count of 1 or more than 1 they also differ in how `ovf_out` is formed. The sweep feeds every count from 0 to 70 at all four sizes and both carry values, so both kinds of zero-effect rotate occur. The bench judges each one against a bit-serial reference whose flag rules depend only on the masked count.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

    localparam int DATA_W    = 64;
    localparam int NUM_SIZES = 4;
    localparam int AMT_W     = 7;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_Q = 2'd3
    } opsize_e;

    // Subtract the ring length as often as it fits (masked counts stay below 64)
    function automatic logic [AMT_W-1:0] ring_reduce(input logic [AMT_W-1:0] m,
                                                     input int ring_len);
        logic [AMT_W-1:0] r;
        r = m;
        for (int k = 3; k >= 1; k--) begin
            if (int'(r) >= k * ring_len) r = r - AMT_W'(k * ring_len);
        end
        return r;
    endfunction

    // XOR of the two top bits of the value inside the selected width
    function automatic logic top_pair_xor(input logic [DATA_W-1:0] v,
                                          input logic [1:0] sz);
        logic x;
        unique case (sz)
            2'd0:    x = v[7]  ^ v[6];
            2'd1:    x = v[15] ^ v[14];
            2'd2:    x = v[31] ^ v[30];
            default: x = v[63] ^ v[62];
        endcase
        return x;
    endfunction

endpackage

// File: rtl/rcr_count_norm.sv
module rcr_count_norm
    import rcr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  opsize_e          size,
    input  logic [CNT_W-1:0] raw,
    output logic [AMT_W-1:0] amount,
    output logic             is_zero,
    output logic             is_one
);
    logic [AMT_W-1:0] masked;

    // Masking width depends on size (R3)
    always_comb begin
        unique case (size)
            SZ_Q:    masked = AMT_W'(raw[5:0]);
            default: masked = AMT_W'(raw[4:0]);
        endcase
    end

    // Narrow rings wrap within the masked range (R4)
    always_comb begin
        unique case (size)
            SZ_B:    amount = ring_reduce(masked, 9);
            SZ_H:    amount = ring_reduce(masked, 17);
            default: amount = masked;
        endcase
    end

    assign is_zero = (masked == '0);
    assign is_one  = (masked == AMT_W'(1));

endmodule

// File: rtl/rcr_ring.sv
module rcr_ring
    import rcr_pkg::*;
(
    input  opsize_e           size,
    input  logic [DATA_W-1:0] operand,
    input  logic              cf_in,
    input  logic [AMT_W-1:0]  amount,
    output logic [DATA_W-1:0] rot_val,
    output logic              rot_cf
);
    logic [DATA_W-1:0] val_a [NUM_SIZES];
    logic              cf_a  [NUM_SIZES];

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_sz
        localparam int W = 8 << g;
        logic [W:0]       ring;
        logic [W:0]       spun;
        logic [AMT_W-1:0] back;

        assign ring = {cf_in, operand[W-1:0]};
        assign back = AMT_W'(W + 1) - amount;
        assign spun = (ring >> amount) | (ring << back);
        assign val_a[g] = DATA_W'(spun[W-1:0]);
        assign cf_a[g]  = spun[W];
    end

    always_comb begin
        unique case (size)
            SZ_B:    begin rot_val = val_a[0]; rot_cf = cf_a[0]; end
            SZ_H:    begin rot_val = val_a[1]; rot_cf = cf_a[1]; end
            SZ_W:    begin rot_val = val_a[2]; rot_cf = cf_a[2]; end
            default: begin rot_val = val_a[3]; rot_cf = cf_a[3]; end
        endcase
    end

endmodule

// File: rtl/rcr_flags.sv
module rcr_flags
    import rcr_pkg::*;
(
    input  opsize_e           size,
    input  logic [DATA_W-1:0] rot_val,
    input  logic              rot_cf,
    input  logic              is_zero,
    input  logic              is_one,
    input  logic              cf_in,
    input  logic              of_in,
    output logic              cf_next,
    output logic              of_next,
    output logic              we_next
);
    always_comb begin
        we_next = !is_zero;
        cf_next = is_zero ? cf_in : rot_cf;
        of_next = is_one ? top_pair_xor(rot_val, size) : of_in;
    end

endmodule

// File: rtl/rcr_unit.sv
module rcr_unit
    import rcr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op_size,
    input  logic [63:0]       operand,
    input  logic [CNT_W-1:0]  raw_count,
    input  logic              carry_in,
    input  logic              ovf_in,
    output logic              out_valid,
    output logic [63:0]       result,
    output logic              carry_out,
    output logic              ovf_out,
    output logic              flags_we
);
    opsize_e           size;
    logic [AMT_W-1:0]  amount;
    logic              is_zero, is_one;
    logic [DATA_W-1:0] rot_val;
    logic              rot_cf;
    logic              cf_next, of_next, we_next;

    assign size = opsize_e'(op_size);

    rcr_count_norm #(.CNT_W(CNT_W)) u_norm (
        .size    (size),
        .raw     (raw_count),
        .amount  (amount),
        .is_zero (is_zero),
        .is_one  (is_one)
    );

    rcr_ring u_ring (
        .size    (size),
        .operand (operand),
        .cf_in   (carry_in),
        .amount  (amount),
        .rot_val (rot_val),
        .rot_cf  (rot_cf)
    );

    rcr_flags u_flags (
        .size    (size),
        .rot_val (rot_val),
        .rot_cf  (rot_cf),
        .is_zero (is_zero),
        .is_one  (is_one),
        .cf_in   (carry_in),
        .of_in   (ovf_in),
        .cf_next (cf_next),
        .of_next (of_next),
        .we_next (we_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            carry_out <= 1'b0;
            ovf_out   <= 1'b0;
            flags_we  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= rot_val;
                carry_out <= cf_next;
                ovf_out   <= of_next;
                flags_we  <= we_next;
            end
        end
    end

    logic cnt_zero_in, cnt_one_in;
    assign cnt_zero_in = (op_size == 2'd3) ? (raw_count[5:0] == 6'd0) : (raw_count[4:0] == 5'd0);
    assign cnt_one_in  = (op_size == 2'd3) ? (raw_count[5:0] == 6'd1) : (raw_count[4:0] == 5'd1);

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R9
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R5
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt_zero_in) |=>
            (!flags_we && carry_out == $past(carry_in) && ovf_out == $past(ovf_in)));
    // R6
    nonzero_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cnt_zero_in) |=> flags_we);
    // R2
    byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_size == 2'd0) |=> (result[63:8] == 56'd0));
    // R4
    byte_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_size == 2'd0 && raw_count[4:0] == 5'd9) |=>
            (flags_we && carry_out == $past(carry_in) && result[7:0] == $past(operand[7:0])));
    // R7
    ovf_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt_one_in) |=> (ovf_out == top_pair_xor(result, $past(op_size))));
    // R8
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cnt_zero_in && !cnt_one_in) |=> (ovf_out == $past(ovf_in)));

endmodule

// File: tb/sim_rcr_unit.sv
`timescale 1ns/1ps
module sim_rcr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_size = 2'd0;
    logic [63:0] operand = '0;
    logic [7:0]  raw_count = '0;
    logic        carry_in = 1'b0;
    logic        ovf_in = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic        carry_out, ovf_out, flags_we;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    rcr_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_size(op_size),
        .operand(operand), .raw_count(raw_count), .carry_in(carry_in), .ovf_in(ovf_in),
        .out_valid(out_valid), .result(result), .carry_out(carry_out),
        .ovf_out(ovf_out), .flags_we(flags_we)
    );

    // Bit-serial reference computed from the requirements
    task automatic reference(input logic [1:0] sz, input logic [63:0] op, input logic [7:0] cnt,
                             input logic ci, input logic oi,
                             output logic [63:0] ev, output logic ec, output logic eo,
                             output logic ew, output int m);
        int w;
        logic nb;
        w = 8 << sz;
        m = (sz == 2'd3) ? int'(cnt[5:0]) : int'(cnt[4:0]);
        ev = (w == 64) ? op : (op & ((64'd1 << w) - 64'd1));
        ec = ci;
        for (int i = 0; i < m; i++) begin
            nb = ev[0];
            ev = ev >> 1;
            ev[w-1] = ec;
            ec = nb;
        end
        ew = (m != 0);
        eo = (m == 1) ? (ev[w-1] ^ ev[w-2]) : oi;
    endtask

    task automatic apply(input logic [1:0] sz, input logic [63:0] op, input logic [7:0] cnt,
                         input logic ci, input logic oi, input string tag);
        logic [63:0] ev;
        logic ec, eo, ew;
        int m;
        reference(sz, op, cnt, ci, oi, ev, ec, eo, ew, m);
        @(negedge clk);
        in_valid = 1'b1; op_size = sz; operand = op; raw_count = cnt;
        carry_in = ci; ovf_in = oi;
        @(negedge clk);
        in_valid = 1'b0;
        checks++;
        if (!out_valid || result !== ev || carry_out !== ec || ovf_out !== eo || flags_we !== ew) begin
            fails++;
            $display("FAIL %s size=%0d cnt=%0d: got v=%0b res=%h cf=%0b of=%0b we=%0b exp v=1 res=%h cf=%0b of=%0b we=%0b",
                     tag, sz, cnt, out_valid, result, carry_out, ovf_out, flags_we, ev, ec, eo, ew);
        end
    endtask

    function automatic string tag_for(input logic [1:0] sz, input logic [7:0] cnt);
        int m;
        m = (sz == 2'd3) ? int'(cnt[5:0]) : int'(cnt[4:0]);
        if (m == 0) return "R5";
        if (m == 1) return "R7";
        if (m > 31 || cnt > 8'd31) return "R3";
        return "R1";
    endfunction

    initial begin
        logic [63:0] pats [6];
        pats[0] = 64'h123456789ABCDEF0;
        pats[1] = 64'hFFFFFFFFFFFFFFFF;
        pats[2] = 64'h8000000000000001;
        pats[3] = 64'hA5A5A5A55A5A5A5A;
        pats[4] = 64'h0000000000000000;
        pats[5] = 64'hFEDCBA9876543210;

        repeat (3) @(negedge clk);
        // R9: reset state
        checks++;
        if (out_valid !== 1'b0 || result !== 64'd0 || carry_out !== 1'b0 || ovf_out !== 1'b0 || flags_we !== 1'b0) begin
            fails++;
            $display("FAIL R9 reset: got v=%0b res=%h cf=%0b of=%0b we=%0b exp all zero",
                     out_valid, result, carry_out, ovf_out, flags_we);
        end
        rst_n = 1'b1;

        // R1 worked examples
        apply(2'd0, 64'h10, 8'd4, 1'b1, 1'b0, "R1");
        apply(2'd1, 64'h1234, 8'd4, 1'b0, 1'b0, "R1");
        apply(2'd3, 64'h123456789ABCDEF0, 8'd16, 1'b0, 1'b0, "R1");
        // R3 masking
        apply(2'd2, 64'h12345678, 8'd33, 1'b0, 1'b1, "R3");
        apply(2'd3, 64'h123456789ABCDEF0, 8'd64, 1'b1, 1'b1, "R3");
        // R4 full ring returns, R6 enable still high
        apply(2'd0, 64'h42, 8'd9, 1'b1, 1'b0, "R4");
        apply(2'd1, 64'h1234, 8'd17, 1'b1, 1'b1, "R4");
        // R2 upper operand bits ignored
        apply(2'd0, 64'hFFFFFFFFFFFFFF00, 8'd3, 1'b0, 1'b0, "R2");
        apply(2'd2, 64'hDEADBEEF00000001, 8'd1, 1'b0, 1'b0, "R2");
        // R8 overflow held for count above one
        apply(2'd2, 64'h80000000, 8'd5, 1'b0, 1'b1, "R8");
        // R5 zero count keeps both flags
        apply(2'd1, 64'hFFFF, 8'd0, 1'b1, 1'b1, "R5");

        // R9: out_valid drops when idle
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R9 idle: got out_valid=%0b exp 0", out_valid);
        end

        // Sweep: all sizes, counts 0..70, both carries, several operands
        for (int s = 0; s < 4; s++)
            for (int c = 0; c <= 70; c++)
                for (int ci = 0; ci < 2; ci++)
                    for (int p = 0; p < 6; p++)
                        apply(2'(s), pats[p], 8'(c), 1'(ci), 1'((c + p) & 1),
                              tag_for(2'(s), 8'(c)));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule